// File: doc/BRIEF.md
# Converter Power-Up Delay Sequencer

This block brings an analog-to-digital converter out of power-down in three timed steps. Software writes three 8-bit delay values and then sets an arming bit. From the cycle the arming bit goes from 0 to 1, the block counts ticks of an external timebase. It raises the regulator enable, then the converter enable, and finally issues a one-cycle start request. Each step waits until the tick count reaches its own programmed delay.

The arming bit is never cleared by hardware. To launch another sampling, software clears the bit and sets it again. Clearing it at any point aborts the chain and drops every output. The tick is expected to come from a prescaler running at 1/8 µs. At that rate the reset values of the delays (0, 0x80, 0x88) give 0 µs, 16 µs and 17 µs, which are the recommended settle times.

Software access goes through a simple 16-bit register port with a single-cycle write strobe and a combinational read path.

Top module: `adc_seq`

## Requirements
- R1: After reset the arming bit is 0, the regulator delay is 0x00, the converter delay is 0x80, the start delay is 0x88, and all three outputs are low.
- R2: The register map is as follows. Address 0 holds the arming bit in bit 0, and its other bits read 0. Address 1 holds the regulator delay in bits 7:0. Address 2 holds the converter delay in bits 7:0 and the start delay in bits 15:8. Address 3 always reads 0, and writes to it change nothing. A write takes effect on the clock edge where `wr_en_i` is high.
- R3: The tick count is zero while the arming bit is 0. It starts counting from zero on the cycle after the arming bit rises. It advances by one on each clock edge where `tick_i` is high and the arming bit is already set.
- R4: `ldo_en_o` is high exactly while the arming bit is 1 and the tick count is at least the regulator delay.
- R5: `conv_en_o` is high exactly while `ldo_en_o` is high and the tick count is at least the converter delay. The converter is therefore never enabled before the regulator, even when the converter delay is smaller.
- R6: `start_o` is a single-cycle pulse. It is issued on the first cycle in which `conv_en_o` is high and the tick count is at least the start delay. It is issued at most once per arming.
- R7: Writing 1 to the arming bit while it is already 1 does not restart the count and does not issue another start pulse.
- R8: Writing 0 to the arming bit drops all three outputs on the cycle after the write. A fresh 0-to-1 write relaunches the chain from count zero.
- R9: The tick count saturates at 255, so a delay of 255 is reached and the outputs then stay asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| tick_i | input | 1 | Timebase tick from the prescaler |
| ldo_en_o | output | 1 | Regulator enable level |
| conv_en_o | output | 1 | Converter enable level |
| start_o | output | 1 | One-cycle conversion start request |

## Verification
The bench targets the following corner cases, and each one shows a specific fault:
- **Delays programmed out of order.** A converter enable that ignores the regulator step would rise too early.
- **Delays of zero.** A design that waits one extra tick would fire a cycle late.
- **Delays of 255.** A wrapping counter would never reach the threshold.
- **A rewrite of 1 while armed.** A level-launched design would restart the count or pulse start a second time.
- **An abort mid-chain followed by a relaunch.** A design that does not clear the count would come up early on the second attempt.
- **A tick coinciding with the arming write.** A counter that accepts it would be one step ahead.

Timing is checked at two rates. The reset delays are run with a tick every cycle. Shorter delays are run with a sparse tick. Both confirm that outputs move only on ticks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int DLY_W   = 8;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int N_STEPS = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DLY_A = 2'd1;
    localparam logic [ADDR_W-1:0] A_DLY_B = 2'd2;

    localparam logic [DLY_W-1:0] RST_LDO   = 8'h00;
    localparam logic [DLY_W-1:0] RST_CONV  = 8'h80;
    localparam logic [DLY_W-1:0] RST_START = 8'h88;

    typedef struct packed {
        logic             arm;
        logic [DLY_W-1:0] d_ldo;
        logic [DLY_W-1:0] d_conv;
        logic [DLY_W-1:0] d_start;
    } cfg_t;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            unique case (addr_i)
                A_CTRL:  cfg_d.arm = wdata_i[0];
                A_DLY_A: cfg_d.d_ldo = wdata_i[DLY_W-1:0];
                A_DLY_B: begin
                    cfg_d.d_conv  = wdata_i[DLY_W-1:0];
                    cfg_d.d_start = wdata_i[2*DLY_W-1:DLY_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.arm     <= 1'b0;
            cfg_q.d_ldo   <= RST_LDO;
            cfg_q.d_conv  <= RST_CONV;
            cfg_q.d_start <= RST_START;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL:  rdata_o[0] = cfg_q.arm;
            A_DLY_A: rdata_o[DLY_W-1:0] = cfg_q.d_ldo;
            A_DLY_B: rdata_o = {cfg_q.d_start, cfg_q.d_conv};
            default: ;
        endcase
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/adc_seq_tbase.sv
module adc_seq_tbase
    import adc_seq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             tick_i,
    output logic [DLY_W-1:0] cnt_o
);
    localparam logic [DLY_W-1:0] CNT_MAX = '1;

    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i)
            cnt_d = '0;
        else if (tick_i && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_seq_steps.sv
module adc_seq_steps
    import adc_seq_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         arm_i,
    input  logic [DLY_W-1:0]             cnt_i,
    input  logic [N_STEPS-1:0][DLY_W-1:0] thr_i,
    output logic [N_STEPS-1:0]           lvl_o,
    output logic                         pulse_o
);
    typedef struct packed {
        logic fired;
    } st_t;

    st_t st_d, st_q;

    for (genvar i = 0; i < N_STEPS; i++) begin : g_step
        if (i == 0) begin : g_first
            assign lvl_o[i] = arm_i && (cnt_i >= thr_i[i]);
        end else begin : g_next
            assign lvl_o[i] = lvl_o[i-1] && (cnt_i >= thr_i[i]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (!arm_i) st_d.fired = 1'b0;
        else if (lvl_o[N_STEPS-1]) st_d.fired = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse_o = lvl_o[N_STEPS-1] && !st_q.fired;
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tick_i,
    output logic              ldo_en_o,
    output logic              conv_en_o,
    output logic              start_o
);
    cfg_t                          cfg;
    logic [DLY_W-1:0]              cnt;
    logic [N_STEPS-1:0][DLY_W-1:0] thr;
    logic [N_STEPS-1:0]            lvl;

    adc_seq_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .cfg_o   (cfg)
    );

    adc_seq_tbase u_tbase (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (cfg.arm),
        .tick_i (tick_i),
        .cnt_o  (cnt)
    );

    assign thr[0] = cfg.d_ldo;
    assign thr[1] = cfg.d_conv;
    assign thr[2] = cfg.d_start;

    adc_seq_steps u_steps (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .arm_i   (cfg.arm),
        .cnt_i   (cnt),
        .thr_i   (thr),
        .lvl_o   (lvl),
        .pulse_o (start_o)
    );

    assign ldo_en_o  = lvl[0];
    assign conv_en_o = lvl[1];
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              tick_i,
    input logic              ldo_en_o,
    input logic              conv_en_o,
    input logic              start_o
);
    // R3
    quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !tick_i) |=> ($stable(ldo_en_o) && $stable(conv_en_o)));

    // R5
    conv_after_ldo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_en_o |-> ldo_en_o);

    // R6
    start_needs_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> conv_en_o);

    // R6
    start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

    // R8
    abort_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_CTRL && !wdata_i[0]) |=>
            (!ldo_en_o && !conv_en_o && !start_o));
endmodule

bind adc_seq adc_seq_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .tick_i    (tick_i),
    .ldo_en_o  (ldo_en_o),
    .conv_en_o (conv_en_o),
    .start_o   (start_o)
);

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic        tick = 1'b0;
    logic [15:0] rdata;
    logic        ldo, conv, start;

    int n_chk = 0;
    int n_bad = 0;
    bit fin   = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_arm = 0, m_cnt = 0, m_fired = 0;
    int m_d0 = 0, m_d1 = 128, m_d2 = 136;

    always #5 clk = ~clk;

    adc_seq u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
        .ldo_en_o(ldo), .conv_en_o(conv), .start_o(start)
    );

    function automatic bit e_ldo();  return m_arm == 1 && m_cnt >= m_d0; endfunction
    function automatic bit e_conv(); return e_ldo() && m_cnt >= m_d1; endfunction
    function automatic bit e_start(); return e_conv() && m_cnt >= m_d2 && m_fired == 0; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_arm = 0; m_cnt = 0; m_fired = 0;
            m_d0 = 0; m_d1 = 128; m_d2 = 136;
        end else begin
            int nf;
            nf = (m_arm == 0) ? 0 : ((m_fired != 0 || e_conv() && m_cnt >= m_d2) ? 1 : 0);
            if (m_arm == 0) m_cnt = 0;
            else if (tick && m_cnt < 255) m_cnt = m_cnt + 1;
            m_fired = nf;
            if (wr) begin
                case (addr)
                    2'd0: m_arm = wdata[0];
                    2'd1: m_d0 = wdata[7:0];
                    2'd2: begin m_d1 = wdata[7:0]; m_d2 = wdata[15:8]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp1(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int er;
        case (addr)
            2'd0: er = m_arm;
            2'd1: er = m_d0;
            2'd2: er = m_d2 * 256 + m_d1;
            default: er = 0;
        endcase
        cmp1("rdata_o", int'(rdata), er);
        cmp1("ldo_en_o", int'(ldo), int'(e_ldo()));
        cmp1("conv_en_o", int'(conv), int'(e_conv()));
        cmp1("start_o", int'(start), int'(e_start()));
    endtask

    task automatic cyc(input bit w, input logic [1:0] a, input logic [15:0] d, input bit t);
        @(negedge clk);
        if (rst_n) compare();
        wr = w; addr = a; wdata = d; tick = t;
    endtask

    task automatic run(input int n, input int every, input logic [1:0] a);
        for (int i = 0; i < n; i++) cyc(0, a, 16'h0, (i % every) == 0);
    endtask

    initial begin
        int starts;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        cur_req = "R1";
        cyc(0, 2'd0, 0, 0); cyc(0, 2'd1, 0, 0); cyc(0, 2'd2, 0, 0); cyc(0, 2'd3, 0, 0);
        // R9? no: R1 reset delays with tick every cycle -> 128 / 136
        cyc(1, 2'd0, 16'h1, 1);
        run(150, 1, 2'd2);
        // R2 register writes and the dead address
        cur_req = "R2";
        cyc(1, 2'd0, 16'h0, 0);
        cyc(1, 2'd1, 16'h0003, 0);
        cyc(1, 2'd2, 16'h0705, 0);
        cyc(1, 2'd3, 16'hFFFF, 0);
        cyc(0, 2'd1, 0, 0); cyc(0, 2'd2, 0, 0); cyc(0, 2'd3, 0, 0); cyc(0, 2'd0, 0, 0);
        // R3 R4 R5 R6 sparse tick, tick on the arming write is not counted
        cur_req = "R4";
        cyc(1, 2'd0, 16'h1, 1);
        run(40, 3, 2'd0);
        // R8 abort mid-chain then relaunch
        cur_req = "R8";
        cyc(1, 2'd0, 16'h0, 1);
        run(3, 1, 2'd0);
        cyc(1, 2'd0, 16'h1, 0);
        run(4, 1, 2'd0);
        cyc(1, 2'd0, 16'h0, 0);
        run(3, 1, 2'd0);
        cyc(1, 2'd0, 16'h1, 0);
        run(20, 1, 2'd0);
        // R7 rewrite 1 while armed
        cur_req = "R7";
        cyc(1, 2'd0, 16'h1, 1);
        run(5, 1, 2'd0);
        if (!ldo) begin n_bad++; $display("FAIL R7 ldo_en_o actual 0 expected 1"); end
        n_chk++;
        starts = 0;
        for (int i = 0; i < 10; i++) begin cyc(0, 2'd0, 0, 1); if (start) starts++; end
        n_chk++;
        if (starts != 0) begin n_bad++; $display("FAIL R7 start count actual %0d expected 0", starts); end
        // R5 misordered delays: conv waits for ldo at 10
        cur_req = "R5";
        cyc(1, 2'd0, 16'h0, 0);
        cyc(1, 2'd1, 16'd10, 0);
        cyc(1, 2'd2, 16'h0402, 0);
        cyc(1, 2'd0, 16'h1, 0);
        run(20, 1, 2'd2);
        // R6 all-zero delays: everything in the first armed cycle, one pulse
        cur_req = "R6";
        cyc(1, 2'd0, 16'h0, 0);
        cyc(1, 2'd1, 16'h0, 0);
        cyc(1, 2'd2, 16'h0000, 0);
        cyc(1, 2'd0, 16'h1, 0);
        starts = 0;
        for (int i = 0; i < 8; i++) begin cyc(0, 2'd0, 0, 1); if (start) starts++; end
        n_chk++;
        if (starts != 1) begin n_bad++; $display("FAIL R6 start count actual %0d expected 1", starts); end
        // R9 saturation at 255
        cur_req = "R9";
        cyc(1, 2'd0, 16'h0, 0);
        cyc(1, 2'd1, 16'd255, 0);
        cyc(1, 2'd2, 16'hFFFF, 0);
        cyc(1, 2'd0, 16'h1, 0);
        run(300, 1, 2'd0);
        n_chk++;
        if (!(ldo && conv)) begin n_bad++; $display("FAIL R9 ldo/conv actual %0b%0b expected 11", ldo, conv); end
        cur_req = "R3";
        run(5, 2, 2'd1);
        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule